// File: doc/BRIEF.md
# Byte-Lane Steering and Access Splitter

This block sits between a processor-side request port and a 16-bit memory. The memory is built from two byte banks that share one set of address lines. A requester presents a byte or word, read or write, at any 20-bit byte address. The block drives an active-low high-bank enable and address bit 0 so that only the addressed lanes take part. It moves write data onto the correct lanes and gathers read data back into a right-justified response.

A word whose first byte sits at an even address finishes in a single memory access. A word that starts at an odd address is cut into two back-to-back byte accesses on opposite lanes, and the two halves are stitched back together. The requester sees no difference except that the request takes one extra cycle. The port holds busy from acceptance until a one-cycle done pulse that follows the last access. Requests presented while busy is high are not taken.

Top module: `byte_lane_splitter`

## Requirements
- R1: After reset, busy, done and memStrobe are all low.
- R2: A word request at an even address produces exactly one access at that address with memHbeN low and memAddr[0] low, and the write data occupies all 16 lanes (low byte on bits 7..0).
- R3: A byte request at an even address produces one access with memHbeN high and memAddr[0] low, and the byte travels on bits 7..0.
- R4: A byte request at an odd address produces one access with memHbeN low and memAddr[0] high, and the byte travels on bits 15..8.
- R5: A word request at odd address N produces two accesses in consecutive cycles. The first is at N with memHbeN low and carries the word's low byte on bits 15..8. The second is at N+1 with memHbeN high and carries the word's high byte on bits 7..0.
- R6: The second access of a split word uses address N+1 modulo 2^20, so that N = 0xFFFFF continues at 0x00000.
- R7: On a read, rspData holds the word in little-endian order: the byte at the request address is in bits 7..0 and the next byte is in bits 15..8. A byte read is zero-extended in bits 7..0. rspData is valid while done is high.
- R8: busy is high from the cycle after acceptance through the done cycle. done is a single-cycle pulse in the cycle right after the last access.
- R9: A request presented while busy is high is not taken: it causes no memory access and no write.
- R10: The combination memHbeN high with memAddr[0] high is never issued during an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present; taken on a clock edge when busy is low |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWord | input | 1 | 1 = word, 0 = byte |
| reqAddr | input | 20 | Byte address of the request |
| reqWdata | input | 16 | Write data; a byte uses bits 7..0 |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rspData | output | 16 | Read response, valid with done |
| memStrobe | output | 1 | Memory access in this cycle |
| memWe | output | 1 | Access is a write |
| memAddr | output | 20 | Byte address; bit 0 is the low-bank select |
| memHbeN | output | 1 | High-bank enable, active low |
| memWdata | output | 16 | Lane-steered write data |
| memRdata | input | 16 | Read data from both banks, same cycle as memStrobe |

## Verification
Two things can land in the same cycle. The first is the done pulse of one request and the arrival of the next request. The bench holds a new request valid straight through the done cycle, and the reference model expects it to be refused there and taken on the following edge. The second is the closing access of a split word and the wrap of the address from 0xFFFFF to 0x00000. This is provoked with odd-word writes and reads at the top byte of the space. It is judged by the second access's address and by the reassembled read-back.

// File: rtl/bls_pkg.sv
package bls_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC1 = 2'd1,
    ST_ACC2 = 2'd2,
    ST_DONE = 2'd3
  } blsState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // register the incoming request
    logic acc1;     // first (or only) memory access
    logic acc2;     // second access of a split word
  } ctrlStrb_t;

endpackage

// File: rtl/bls_ctrl.sv
module bls_ctrl
  import bls_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      reqValid,
  input  logic      splitNeeded,
  output ctrlStrb_t strb,
  output logic      busy,
  output logic      done,
  output logic      memStrobe
);

  blsState_e stQ, stD;

  always_comb begin
    stD  = stQ;
    strb = '0;
    unique case (stQ)
      ST_IDLE: begin
        if (reqValid) begin
          strb.capture = 1'b1;
          stD          = ST_ACC1;
        end
      end
      ST_ACC1: begin
        strb.acc1 = 1'b1;
        stD       = splitNeeded ? ST_ACC2 : ST_DONE;
      end
      ST_ACC2: begin
        strb.acc2 = 1'b1;
        stD       = ST_DONE;
      end
      ST_DONE: stD = ST_IDLE;
      default: stD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stQ <= ST_IDLE;
    else        stQ <= stD;
  end

  assign busy      = (stQ != ST_IDLE);
  assign done      = (stQ == ST_DONE);
  assign memStrobe = (stQ == ST_ACC1) || (stQ == ST_ACC2);

  // R8: completion is a single pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: completion always directly follows an access
  a_r8_done_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(memStrobe));

  // R9: once busy, nothing restarts the port before done
  a_r9_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R5: second access only directly after the first
  a_r5_acc2_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (stQ == ST_ACC2) |-> ($past(stQ) == ST_ACC1));

endmodule

// File: rtl/bls_dp.sv
module bls_dp
  import bls_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrlStrb_t           strb,
  input  logic                reqWrite,
  input  logic                reqWord,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [2*LANE_W-1:0] reqWdata,
  input  logic [2*LANE_W-1:0] memRdata,
  output logic                splitNeeded,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memHbeN,
  output logic [2*LANE_W-1:0] memWdata,
  output logic [2*LANE_W-1:0] rspData
);

  localparam int DATA_W = 2 * LANE_W;

  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] addrNext;
  logic              wordQ, writeQ;
  logic [DATA_W-1:0] wdataQ, rspQ;
  logic [LANE_W-1:0] loLaneIn, hiLaneIn;
  logic              accessing;

  assign addrNext    = addrQ + ADDR_W'(1);  // wraps modulo 2^ADDR_W
  assign splitNeeded = wordQ & addrQ[0];
  assign accessing   = strb.acc1 | strb.acc2;
  assign memWe       = writeQ & accessing;
  assign loLaneIn    = memRdata[LANE_W-1:0];
  assign hiLaneIn    = memRdata[DATA_W-1:LANE_W];
  assign rspData     = rspQ;

  // lane steering of address, enables and write data
  always_comb begin
    memAddr  = addrQ;
    memHbeN  = 1'b1;
    memWdata = '0;
    if (strb.acc2) begin
      memAddr                  = addrNext;
      memWdata[LANE_W-1:0]     = wdataQ[DATA_W-1:LANE_W];
    end else if (wordQ && !addrQ[0]) begin
      memHbeN  = 1'b0;
      memWdata = wdataQ;
    end else if (addrQ[0]) begin
      memHbeN                  = 1'b0;
      memWdata[DATA_W-1:LANE_W] = wdataQ[LANE_W-1:0];
    end else begin
      memWdata[LANE_W-1:0]     = wdataQ[LANE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ  <= '0;
      wordQ  <= 1'b0;
      writeQ <= 1'b0;
      wdataQ <= '0;
      rspQ   <= '0;
    end else if (strb.capture) begin
      addrQ  <= reqAddr;
      wordQ  <= reqWord;
      writeQ <= reqWrite;
      wdataQ <= reqWdata;
      rspQ   <= '0;
    end else if (strb.acc1 && !writeQ) begin
      unique case ({wordQ, addrQ[0]})
        2'b10:   rspQ <= memRdata;
        2'b11:   rspQ <= {{LANE_W{1'b0}}, hiLaneIn};
        2'b01:   rspQ <= {{LANE_W{1'b0}}, hiLaneIn};
        default: rspQ <= {{LANE_W{1'b0}}, loLaneIn};
      endcase
    end else if (strb.acc2 && !writeQ) begin
      rspQ[DATA_W-1:LANE_W] <= loLaneIn;
    end
  end

  // R10: the empty enable combination never reaches the banks
  a_r10_no_void_enable: assert property (@(posedge clk) disable iff (!rst_n)
    accessing |-> !(memHbeN && memAddr[0]));

  // R5: the closing access of a split uses only the low lane at an even address
  a_r5_second_low_lane: assert property (@(posedge clk) disable iff (!rst_n)
    strb.acc2 |-> (memHbeN && !memAddr[0]));

  // R6: the closing access addresses the byte after the first, with wrap
  a_r6_next_address: assert property (@(posedge clk) disable iff (!rst_n)
    strb.acc2 |-> (memAddr == $past(memAddr) + ADDR_W'(1)));

endmodule

// File: rtl/byte_lane_splitter.sv
module byte_lane_splitter
  import bls_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic                reqWord,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [2*LANE_W-1:0] reqWdata,
  output logic                busy,
  output logic                done,
  output logic [2*LANE_W-1:0] rspData,
  output logic                memStrobe,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memHbeN,
  output logic [2*LANE_W-1:0] memWdata,
  input  logic [2*LANE_W-1:0] memRdata
);

  ctrlStrb_t strb;
  logic      splitNeeded;

  bls_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .reqValid    (reqValid),
    .splitNeeded (splitNeeded),
    .strb        (strb),
    .busy        (busy),
    .done        (done),
    .memStrobe   (memStrobe)
  );

  bls_dp #(
    .ADDR_W (ADDR_W),
    .LANE_W (LANE_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .reqWrite    (reqWrite),
    .reqWord     (reqWord),
    .reqAddr     (reqAddr),
    .reqWdata    (reqWdata),
    .memRdata    (memRdata),
    .splitNeeded (splitNeeded),
    .memWe       (memWe),
    .memAddr     (memAddr),
    .memHbeN     (memHbeN),
    .memWdata    (memWdata),
    .rspData     (rspData)
  );

  // R1: idle port never strobes the memory
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !memStrobe);

endmodule

// File: tb/byte_lane_splitter_bench.sv
module byte_lane_splitter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqWord = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        busy, done, memStrobe, memWe, memHbeN;
  logic [15:0] rspData, memWdata;
  logic [19:0] memAddr;
  logic [15:0] memRdata = '0;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #10 clk = ~clk;  // 50 MHz

  byte_lane_splitter u_byte_lane_splitter (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWord(reqWord), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .busy(busy), .done(done), .rspData(rspData), .memStrobe(memStrobe),
    .memWe(memWe), .memAddr(memAddr), .memHbeN(memHbeN),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  // ---------------- memories: one for the design, one for the model
  logic [7:0] dutMem[int];
  logic [7:0] refMem[int];

  function automatic logic [7:0] pat(int a);
    return 8'(a * 7 + 3);
  endfunction
  function automatic logic [7:0] rdDut(int a);
    return dutMem.exists(a) ? dutMem[a] : pat(a);
  endfunction
  function automatic logic [7:0] rdRef(int a);
    return refMem.exists(a) ? refMem[a] : pat(a);
  endfunction

  always @(negedge clk) begin
    if (memStrobe && memWe) begin
      if (!memHbeN)   dutMem[int'({memAddr[19:1], 1'b1})] = memWdata[15:8];
      if (!memAddr[0]) dutMem[int'({memAddr[19:1], 1'b0})] = memWdata[7:0];
    end
    memRdata = {rdDut(int'({memAddr[19:1], 1'b1})), rdDut(int'({memAddr[19:1], 1'b0}))};
  end

  // ---------------- reference model: expected port values per cycle
  typedef struct {
    bit          strobe, busy, done, we, hbeN, rspChk;
    logic [19:0] addr;
    bit   [1:0]  mask;
    logic [15:0] wdata, rsp;
    string       tag;
  } rec_t;

  rec_t q[$];

  function automatic rec_t idleRec();
    rec_t r;
    r.strobe = 0; r.busy = 0; r.done = 0; r.we = 0; r.hbeN = 1; r.rspChk = 0;
    r.addr = '0; r.mask = 2'b00; r.wdata = '0; r.rsp = '0; r.tag = "R9";
    return r;
  endfunction

  function automatic void pushTxn(bit w, bit wd, logic [19:0] a, logic [15:0] d);
    rec_t acc = idleRec();
    rec_t acc2 = idleRec();
    rec_t fin = idleRec();
    logic [19:0] nxt = a + 20'd1;
    acc.strobe = 1; acc.busy = 1; acc.we = w; acc.addr = a;
    fin.busy = 1; fin.done = 1; fin.rspChk = !w; fin.tag = "R7";
    if (wd && !a[0]) begin        // R2
      acc.tag = "R2"; acc.hbeN = 0; acc.mask = 2'b11; acc.wdata = d;
      fin.rsp = {rdRef(int'(nxt)), rdRef(int'(a))};
      if (w) begin refMem[int'(a)] = d[7:0]; refMem[int'(nxt)] = d[15:8]; end
      q.push_back(acc);
    end else if (wd) begin        // R5 / R6
      acc.tag = "R5"; acc.hbeN = 0; acc.mask = 2'b10; acc.wdata = {d[7:0], 8'h00};
      acc2 = acc; acc2.tag = "R6"; acc2.addr = nxt; acc2.hbeN = 1;
      acc2.mask = 2'b01; acc2.wdata = {8'h00, d[15:8]};
      fin.rsp = {rdRef(int'(nxt)), rdRef(int'(a))};
      if (w) begin refMem[int'(a)] = d[7:0]; refMem[int'(nxt)] = d[15:8]; end
      q.push_back(acc); q.push_back(acc2);
    end else if (a[0]) begin      // R4
      acc.tag = "R4"; acc.hbeN = 0; acc.mask = 2'b10; acc.wdata = {d[7:0], 8'h00};
      fin.rsp = {8'h00, rdRef(int'(a))};
      if (w) refMem[int'(a)] = d[7:0];
      q.push_back(acc);
    end else begin                // R3
      acc.tag = "R3"; acc.hbeN = 1; acc.mask = 2'b01; acc.wdata = {8'h00, d[7:0]};
      fin.rsp = {8'h00, rdRef(int'(a))};
      if (w) refMem[int'(a)] = d[7:0];
      q.push_back(acc);
    end
    q.push_back(fin);
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      bit wasBusy;
      wasBusy = (q.size() > 0);
      if (wasBusy) void'(q.pop_front());
      if (reqValid && !wasBusy) pushTxn(reqWrite, reqWord, reqAddr, reqWdata);
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      rec_t e;
      e = (q.size() > 0) ? q[0] : idleRec();
      chk("R8", "busy", 32'(busy), 32'(e.busy));
      chk("R8", "done", 32'(done), 32'(e.done));
      chk(e.strobe ? e.tag : "R9", "memStrobe", 32'(memStrobe), 32'(e.strobe));
      if (e.strobe) begin
        chk(e.tag, "memAddr", 32'(memAddr), 32'(e.addr));
        chk(e.tag, "memHbeN", 32'(memHbeN), 32'(e.hbeN));
        chk(e.tag, "memWe", 32'(memWe), 32'(e.we));
        chk("R10", "enable pair", 32'(memHbeN & memAddr[0]), 32'd0);
        if (e.we && e.mask[0]) chk(e.tag, "low lane", 32'(memWdata[7:0]), 32'(e.wdata[7:0]));
        if (e.we && e.mask[1]) chk(e.tag, "high lane", 32'(memWdata[15:8]), 32'(e.wdata[15:8]));
      end
      if (e.done && e.rspChk) chk("R7", "rspData", 32'(rspData), 32'(e.rsp));
    end
  end

  // ---------------- stimulus
  // holds a request valid until the edge on which the port was idle
  task automatic sendHold(bit w, bit wd, logic [19:0] a, logic [15:0] d);
    logic b;
    reqValid = 1; reqWrite = w; reqWord = wd; reqAddr = a; reqWdata = d;
    do begin
      b = busy;
      @(negedge clk);
    end while (b);
    reqValid = 0;
  endtask

  // R9: offer a write only during cycles in which the port is busy
  task automatic pokeBusy(logic [19:0] a, logic [15:0] d);
    while (busy) begin
      reqValid = 1; reqWrite = 1; reqWord = 1; reqAddr = a; reqWdata = d;
      @(negedge clk);
    end
    reqValid = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected<=50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "busy", 32'(busy), 32'd0);
    chk("R1", "done", 32'(done), 32'd0);
    chk("R1", "memStrobe", 32'(memStrobe), 32'd0);
    rst_n = 1;
    @(negedge clk);

    sendHold(1, 1, 20'h00100, 16'hA1B2);  // R2 even word write
    sendHold(0, 1, 20'h00100, 16'h0000);  // R7 read back, held through done
    sendHold(1, 0, 20'h00200, 16'h0055);  // R3 even byte
    sendHold(1, 0, 20'h00201, 16'h0066);  // R4 odd byte
    sendHold(0, 1, 20'h00200, 16'h0000);
    sendHold(0, 0, 20'h00201, 16'h0000);
    sendHold(0, 0, 20'h00200, 16'h0000);
    sendHold(1, 1, 20'h00301, 16'hC3D4);  // R5 split write
    sendHold(0, 1, 20'h00301, 16'h0000);  // R5 split read
    sendHold(0, 1, 20'h00300, 16'h0000);
    sendHold(1, 1, 20'hFFFFF, 16'h1234);  // R6 wrap write
    sendHold(0, 1, 20'hFFFFF, 16'h0000);  // R6 wrap read
    sendHold(0, 0, 20'h00000, 16'h0000);

    // R9: writes offered while busy must leave 0x500 untouched
    sendHold(1, 1, 20'h00400, 16'h7788);
    pokeBusy(20'h00500, 16'hEEEE);
    repeat (2) @(negedge clk);
    sendHold(1, 1, 20'h00401, 16'h99AA);
    pokeBusy(20'h00500, 16'hEEEE);
    repeat (2) @(negedge clk);
    sendHold(0, 1, 20'h00500, 16'h0000);

    for (int i = 0; i < 400; i++) begin
      logic [19:0] a;
      a = (($urandom & 1) != 0 ? 20'hFFFF0 : 20'h00600) + 20'($urandom_range(0, 15));
      sendHold(1'($urandom), 1'($urandom), a, 16'($urandom));
      if (($urandom & 3) == 0) @(negedge clk);
    end

    repeat (6) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule